// File: doc/BRIEF.md
# Watchdog Timer with Selectable Interrupt or Reset Action

This block counts ticks of a slow timebase, nominally 32.768 kHz, delivered as a one-cycle `tick_en` strobe in the system clock domain. When software fails to service it within the timeout period, the count overflows. The block then raises one of two single-cycle pulses: a non-maskable interrupt on `nmi`, or a system reset request on `wdt_reset`. A mode bit chooses which pulse fires. The counter then wraps to zero and keeps counting. The default period is 131072 ticks, which is four seconds at 32.768 kHz.

Software reaches the block through two byte-wide locations, selected by `addr`:
- **Control byte (`addr`=0).** Holds a 4-bit run field and a self-clearing kick bit.
- **Status byte (`addr`=1).** Holds the mode bit and a sticky overflow flag.

The timer comes out of reset stopped. Software should start it and kick it in one write, so that no stale count causes an early overflow.

The control path is a four-state machine:
- **HALT.** The run field holds the stop key.
- **RUN.** The counter advances on ticks.
- **NMI_FIRE.** One cycle that drives `nmi`.
- **RST_FIRE.** One cycle that drives `wdt_reset`.

Its transitions are:
- **start:** HALT to RUN, when a control write stores any value other than the key.
- **stop:** RUN to HALT, when the key is stored.
- **expire:** RUN to NMI_FIRE or RST_FIRE, on overflow, depending on the mode bit.
- **resume:** a fire state to RUN, or to HALT if the key is now stored.

The counter itself advances whenever the stored run field is not the key.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is released, the control byte reads 0x0A, the status byte reads 0x00, and `nmi` and `wdt_reset` are low.
- R2: The run field is control bits 3:0, and it is readable and writable. When it holds 4'b1010, ticks are ignored and the count holds. Any other value lets the count advance by one per `tick_en`. Resuming without a kick continues from the held count.
- R3: Exactly TIMEOUT_TICKS ticks after a kick, the counter overflows. The selected output is high for exactly one clock, in the cycle after the clock edge that sampled the final tick. The counter then wraps to zero, and a further TIMEOUT_TICKS ticks cause another overflow.
- R4: Writing a 1 to control bit 4 (the kick bit) clears the count to zero. Writing 0 there has no effect on the count. Bit 4 always reads back as 0.
- R5: When a kick and a tick arrive in the same cycle, the clear wins. No overflow occurs even if the count was at its last value, and a full TIMEOUT_TICKS period follows.
- R6: Status bit 1 is the mode bit, and it resets to 0. With mode 0, an overflow pulses `nmi`. With mode 1, it pulses `wdt_reset`. The two outputs are never high together.
- R7: Status bit 0 sets on every overflow and clears only on a kick. Writes to it are ignored. Status bits 7:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe from the slow timebase |
| addr | input | 1 | 0 selects the control byte, 1 selects the status byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rd_data` is 0 when it is low |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational while `rd_en` is high |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |
| wdt_reset | output | 1 | One-cycle system reset request pulse |

## Verification
The bench sweeps all fifteen non-key run values and times each overflow tick by tick. A stop rule that decoded only some bits of the key would show up as a timer that never stops or never starts. An off-by-one limit would move the pulse one tick early or late. A kick placed in the same cycle as the final tick catches a design where the increment beats the clear, because that design would fire a spurious interrupt. Resuming after a stop without a kick, and writing a zero kick bit, expose a design that clears the count on any control write. Writing all ones to the status byte exposes a writable flag or leaking reserved bits.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_NMI   = 2'd2,
        ST_RST   = 2'd3
    } wd_state_e;

    localparam logic [3:0] STOP_KEY   = 4'b1010;
    localparam int         KICK_POS   = 4;
    localparam int         MODE_POS   = 1;
    localparam int         FLAG_POS   = 0;
    localparam int         RUN_W      = 4;
    localparam int         BYTE_W     = 8;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wrap,
    output logic [BYTE_W-1:0] rd_data,
    output logic              kick,
    output logic              running,
    output logic              run_next,
    output logic              mode
);

    logic [RUN_W-1:0] run_q;
    logic             mode_q;
    logic             flag_q;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             unused_hi;

    assign wr_ctrl   = wr_en && !addr;
    assign wr_stat   = wr_en && addr;
    assign kick      = wr_ctrl && wr_data[KICK_POS];
    assign running   = (run_q != STOP_KEY);
    assign run_next  = wr_ctrl ? (wr_data[RUN_W-1:0] != STOP_KEY) : running;
    assign mode      = mode_q;
    assign unused_hi = ^wr_data[BYTE_W-1:KICK_POS+1];

    // Run field and mode bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= STOP_KEY;
            mode_q <= 1'b0;
        end else begin
            if (wr_ctrl) run_q  <= wr_data[RUN_W-1:0];
            if (wr_stat) mode_q <= wr_data[MODE_POS];
        end
    end

    // Sticky overflow flag: set by overflow, cleared only by kick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (kick)   flag_q <= 1'b0;
        else if (wrap)   flag_q <= 1'b1;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (addr) begin
                rd_data[MODE_POS] = mode_q;
                rd_data[FLAG_POS] = flag_q;
            end else begin
                rd_data[RUN_W-1:0] = run_q;
            end
        end
    end

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !flag_q);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !kick) |=> flag_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic running,
    input  logic kick,
    output logic wrap
);

    localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             step;
    logic             at_last;

    assign step    = tick_en && running && !kick;
    assign at_last = (cnt_q == LAST);
    assign wrap    = step && at_last;

    always_comb begin
        cnt_d = cnt_q;
        if (kick)         cnt_d = '0;
        else if (step)    cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!kick && (!running || !tick_en)) |=> $stable(cnt_q));
    p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));
    p_kick_beats_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && tick_en) |-> !wrap);
    p_step_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_last) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_wraps_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic mode,
    input  logic run_next,
    input  logic running,
    output logic nmi,
    output logic wdt_reset
);

    wd_state_e state_q;
    wd_state_e state_d;

    // Next-state logic: expire beats start/stop/resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: state_d = run_next ? ST_RUN : ST_HALT;
            ST_RUN,
            ST_NMI,
            ST_RST: begin
                if (wrap)          state_d = mode ? ST_RST : ST_NMI;
                else if (run_next) state_d = ST_RUN;
                else               state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        nmi       = 1'b0;
        wdt_reset = 1'b0;
        unique case (state_q)
            ST_NMI:  nmi       = 1'b1;
            ST_RST:  wdt_reset = 1'b1;
            default: ;
        endcase
    end

    p_halt_means_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !running);
    p_nmi_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);
    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi && wdt_reset));
    p_nmi_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !mode) |=> nmi);
    p_rst_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode) |=> wdt_reset);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 131072
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       nmi,
    output logic       wdt_reset
);

    logic kick;
    logic running;
    logic run_next;
    logic mode;
    logic wrap;

    wdog_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .wrap     (wrap),
        .rd_data  (rd_data),
        .kick     (kick),
        .running  (running),
        .run_next (run_next),
        .mode     (mode)
    );

    wdog_counter #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .running (running),
        .kick    (kick),
        .wrap    (wrap)
    );

    wdog_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .mode      (mode),
        .run_next  (run_next),
        .running   (running),
        .nmi       (nmi),
        .wdt_reset (wdt_reset)
    );

endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;

    localparam int CLK_PERIOD = 10;
    localparam int L          = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       nmi;
    logic       wdt_reset;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_top #(.TIMEOUT_TICKS(L)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .nmi(nmi), .wdt_reset(wdt_reset)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr_tick(input logic [7:0] d);
        wr_en = 1'b1; addr = 1'b0; wr_data = d; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1;
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Ticks until a pulse; idx=0 when none within maxn
    task automatic tick_until(input int maxn, output int idx, output logic got_nmi,
                              output logic got_rst);
        idx = 0; got_nmi = 1'b0; got_rst = 1'b0;
        for (int i = 1; i <= maxn; i++) begin
            tick();
            if (nmi || wdt_reset) begin
                idx = i; got_nmi = nmi; got_rst = wdt_reset;
                break;
            end
        end
    endtask

    task automatic idle_check_low(input string req);
        @(negedge clk);
        check(!nmi && !wdt_reset, req, {nmi, wdt_reset}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int         idx;
        logic       gn, gr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check(v == 8'h0A, "R1 control", v, 8'h0A);
        rd(1'b1, v); check(v == 8'h00, "R1 status", v, 0);
        check(!nmi && !wdt_reset, "R1 outputs", {nmi, wdt_reset}, 0);

        // R2 stopped by default
        tick_until(L + 8, idx, gn, gr);
        check(idx == 0, "R2 halted default", idx, 0);

        // R3/R2/R4/R7 sweep over every run value other than the key
        for (int k = 0; k < 16; k++) begin
            if (k == 10) continue;
            wr(1'b0, 8'h10 | 8'(k));
            rd(1'b0, v); check(v == 8'(k), "R2 R4 run readback, kick reads 0", v, k);
            tick_until(L + 4, idx, gn, gr);
            check(idx == L && gn && !gr, "R3 timeout tick", idx, L);
            idle_check_low("R3 single-cycle pulse");
            rd(1'b1, v); check(v == 8'h01, "R7 flag set", v, 1);
            wr(1'b0, 8'h1A);
            rd(1'b1, v); check(v == 8'h00, "R7 kick clears flag", v, 0);
        end

        // R4 zero kick bit leaves count alone
        wr(1'b0, 8'h15);
        repeat (5) tick();
        wr(1'b0, 8'h05);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L - 5, "R4 no-kick write keeps count", idx, L - 5);

        // R4 kick midway restarts the period
        wr(1'b0, 8'h13);
        repeat (7) tick();
        wr(1'b0, 8'h13);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L, "R4 kick restarts", idx, L);

        // R2 stop holds the count, resume continues
        wr(1'b0, 8'h11);
        repeat (6) tick();
        wr(1'b0, 8'h0A);
        tick_until(3 * L, idx, gn, gr);
        check(idx == 0, "R2 stopped ignores ticks", idx, 0);
        wr(1'b0, 8'h01);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L - 6, "R2 resume from held count", idx, L - 6);

        // R3 wrap and continue; R7 flag survives non-kick write
        wr(1'b0, 8'h03);
        rd(1'b1, v); check(v == 8'h01, "R7 flag sticky", v, 1);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L, "R3 second overflow after wrap", idx, L);

        // R5 kick and final tick coincide
        wr(1'b0, 8'h14);
        repeat (L - 1) tick();
        wr_tick(8'h14);
        check(!nmi && !wdt_reset, "R5 no overflow on kick+tick", {nmi, wdt_reset}, 0);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L, "R5 full period after kick+tick", idx, L);

        // R6/R7 reset mode, reserved bits, read-only flag
        wr(1'b0, 8'h14);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check(v == 8'h02, "R7 reserved zero, flag read-only; R6 mode", v, 2);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L && gr && !gn, "R6 reset request in mode 1", idx, L);
        idle_check_low("R6 reset pulse single cycle");
        rd(1'b1, v); check(v == 8'h03, "R7 flag set in reset mode", v, 3);

        // R6 back to interrupt mode
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h14);
        tick_until(L + 4, idx, gn, gr);
        check(idx == L && gn && !gr, "R6 interrupt in mode 0", idx, L);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule